// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps a two-bank SDRAM alive. A down-counter measures the refresh interval in steps of 16 bus clocks. When the interval runs out, the block marks a refresh as owed and asks the access arbiter for the bus. Once it holds the grant, it sends precharge-all and then auto-refresh to both banks. After each refresh it holds an activate-lockout output high for a recovery time that a 2-bit code selects, so the access side cannot open a row too soon.

Software can also place the memories in self-refresh through a level-sensitive request input. While the request is high, the block gets the bus and precharges. It issues one refresh, then sends the self-refresh entry command in the same cycle that it pulls clock enable low. The refresh timer is frozen while the memories refresh themselves. When the request drops, the block sends the exit command and raises clock enable. It then keeps the bus quiet for the longest recovery time, restarts the timer from a full interval and releases the bus. When clock enable is configured to carry command information, the self-refresh request is ignored.

Top module: `sdr_rfsh_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after its release: `cke` is 1, `cmd_code` is 0 (no operation), `bus_req` is 0 and `act_block` is 0.
- R2: Let INT = (`cfg_interval` + 1) × 16. The first refresh bus request appears INT + 2 rising edges after reset release. With the grant given at once, later requests rise every INT cycles.
- R3: `bus_req` stays high with no command while `bus_gnt` is low. On the first edge after the grant is seen, `cmd_code` shows precharge-all (1). On the next edge it shows refresh (2). Both are sent with `cmd_bank_en` = 2'b11.
- R4: From the cycle that shows refresh, `act_block` stays high for N cycles and goes low on cycle N. N is 3 for `cfg_recov` = 00, 6 for 01, and 9 for 10 or 11.
- R5: With `cfg_sr_req` = 1 and `cfg_cke_cmd_mode` = 0, the block issues precharge-all, then exactly one refresh, then self-refresh entry (code 3). `cke` goes low in the same cycle as the entry command and stays high before it.
- R6: While in self-refresh, `cke` stays low, no command is issued and no refresh request arises, however long the state lasts.
- R7: One edge after `cfg_sr_req` is seen low in self-refresh, the block shows self-refresh exit (code 4) with `cke` high. The next 8 cycles show no command, with `act_block` and `bus_req` high. Both go low in the ninth cycle after the exit command.
- R8: After self-refresh exit the interval restarts from full. The next refresh request rises INT + 10 cycles after the exit command.
- R9: With `cfg_cke_cmd_mode` = 1, `cfg_sr_req` has no effect: `cke` stays high, no entry command is issued, and periodic refresh continues.
- R10: The exit command is issued only from self-refresh. Dropping `cfg_sr_req` at any other time issues no exit command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_interval | input | 9 | Refresh interval in units of 16 clocks, minus one |
| cfg_recov | input | 2 | Post-refresh activate recovery code |
| cfg_sr_req | input | 1 | Level request to hold the memories in self-refresh |
| cfg_cke_cmd_mode | input | 1 | 1 when clock enable carries command information |
| bus_gnt | input | 1 | Grant from the access arbiter |
| bus_req | output | 1 | Request for bus ownership |
| cmd_code | output | 3 | 0 none, 1 precharge-all, 2 refresh, 3 self-refresh entry, 4 self-refresh exit |
| cmd_bank_en | output | 2 | Per-bank select for the current command |
| cke | output | 1 | SDRAM clock enable |
| act_block | output | 1 | High while activate commands must be held off |

## Verification
The assertions assume that the arbiter keeps `bus_gnt` high for as long as `bus_req` stays high once it has granted. They also assume that the configuration inputs do not change inside a refresh or entry sequence. The bench either loops `bus_req` back as the grant or holds a manual grant until the request drops. It changes configuration only through a reset or between sequences, after a refresh has finished and well before the next interval expires.

// File: rtl/sdr_rfsh_pkg.sv
package sdr_rfsh_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PALL = 3'd1,
    CMD_REF  = 3'd2,
    CMD_SRE  = 3'd3,
    CMD_SRX  = 3'd4
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_PALL, ST_REF, ST_SRE, ST_SELF, ST_SRX, ST_RECOV
  } seq_state_e;

  localparam int unsigned RECOV_MAX = 9;
  localparam int unsigned LOCK_W    = $clog2(RECOV_MAX + 1);

  // Recovery clocks between refresh and next activate.
  function automatic logic [LOCK_W-1:0] recov_clks(input logic [1:0] code);
    case (code)
      2'b00:   recov_clks = LOCK_W'(3);
      2'b01:   recov_clks = LOCK_W'(6);
      default: recov_clks = LOCK_W'(RECOV_MAX);
    endcase
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned RC_W       = 9,
  parameter int unsigned UNIT_SHIFT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RC_W-1:0] cfg_interval,
  input  logic            hold,
  input  logic            reload,
  output logic            expire
);
  localparam int unsigned CNT_W = RC_W + UNIT_SHIFT;

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             init_q;
  logic             cnt_en;

  // (interval + 1) * 16 - 1
  assign load_val = {cfg_interval, {UNIT_SHIFT{1'b1}}};

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    cnt_en = 1'b1;
    if (reload || init_q) begin
      cnt_d = load_val;
    end else if (hold) begin
      cnt_en = 1'b0;
    end else if (cnt_q == '0) begin
      expire = 1'b1;
      cnt_d  = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      init_q <= 1'b1;
    end else begin
      init_q <= 1'b0;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rfsh_act_lockout.sv
module rfsh_act_lockout #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/rfsh_seq_ctrl.sv
module rfsh_seq_ctrl
  import sdr_rfsh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       cfg_sr_req,
  input  logic       cfg_cke_cmd_mode,
  input  logic       bus_gnt,
  input  logic       lock_last,
  output seq_state_e state
);
  seq_state_e state_q, state_d;
  logic       pend_q, pend_en;
  logic       sr_want;

  assign sr_want = cfg_sr_req && !cfg_cke_cmd_mode;
  // Owed refresh: set by expiry, cleared when refresh goes out.
  assign pend_en = expire || (state_q == ST_REF);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (pend_q || sr_want) state_d = ST_REQ;
      ST_REQ:   if (bus_gnt) state_d = ST_PALL;
      ST_PALL:  state_d = ST_REF;
      ST_REF:   state_d = sr_want ? ST_SRE : ST_IDLE;
      ST_SRE:   state_d = ST_SELF;
      ST_SELF:  if (!cfg_sr_req) state_d = ST_SRX;
      ST_SRX:   state_d = ST_RECOV;
      ST_RECOV: if (lock_last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pend_en) pend_q <= expire;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/sdr_rfsh_seq.sv
module sdr_rfsh_seq
  import sdr_rfsh_pkg::*;
#(
  parameter int unsigned RC_W      = 9,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RC_W-1:0]      cfg_interval,
  input  logic [1:0]           cfg_recov,
  input  logic                 cfg_sr_req,
  input  logic                 cfg_cke_cmd_mode,
  input  logic                 bus_gnt,
  output logic                 bus_req,
  output logic [2:0]           cmd_code,
  output logic [NUM_BANKS-1:0] cmd_bank_en,
  output logic                 cke,
  output logic                 act_block
);
  seq_state_e        state;
  logic              expire, t_hold, t_reload;
  logic              lk_load, lk_busy, lk_last;
  logic [LOCK_W-1:0] lk_val;
  sdr_cmd_e          cmd;

  assign t_hold   = (state == ST_SRE) || (state == ST_SELF) || (state == ST_SRX);
  assign t_reload = (state == ST_RECOV);

  rfsh_interval_timer #(.RC_W(RC_W), .UNIT_SHIFT(4)) u_timer (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
    .hold(t_hold), .reload(t_reload), .expire(expire)
  );

  assign lk_load = (state == ST_REF) || (state == ST_SRX);
  assign lk_val  = (state == ST_REF) ? recov_clks(cfg_recov) - 1'b1
                                     : LOCK_W'(RECOV_MAX - 1);

  rfsh_act_lockout #(.W(LOCK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(lk_load), .load_val(lk_val),
    .busy(lk_busy), .last(lk_last)
  );

  rfsh_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .expire(expire), .cfg_sr_req(cfg_sr_req),
    .cfg_cke_cmd_mode(cfg_cke_cmd_mode), .bus_gnt(bus_gnt),
    .lock_last(lk_last), .state(state)
  );

  always_comb begin
    case (state)
      ST_PALL: cmd = CMD_PALL;
      ST_REF:  cmd = CMD_REF;
      ST_SRE:  cmd = CMD_SRE;
      ST_SRX:  cmd = CMD_SRX;
      default: cmd = CMD_NOP;
    endcase
  end

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign cmd_bank_en[b] = (cmd != CMD_NOP);
    end
  endgenerate

  assign cmd_code  = cmd;
  assign bus_req   = (state != ST_IDLE);
  assign cke       = !((state == ST_SRE) || (state == ST_SELF));
  assign act_block = (state != ST_IDLE) || lk_busy;
endmodule

// File: rtl/sdr_rfsh_seq_chk.sv
module sdr_rfsh_seq_chk
  import sdr_rfsh_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_cke_cmd_mode,
  input logic                 bus_gnt,
  input logic                 bus_req,
  input logic [2:0]           cmd_code,
  input logic [NUM_BANKS-1:0] cmd_bank_en,
  input logic                 cke,
  input logic                 act_block
);
  AST_PALL_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PALL) |-> ($past(bus_gnt) && $past(bus_req))); // R3
  AST_REF_AFTER_PALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_REF) |-> ($past(cmd_code) == CMD_PALL)); // R3
  AST_CMD_HAS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code != CMD_NOP) |-> (bus_gnt && (&cmd_bank_en))); // R3
  AST_LOCK_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_REF) |=> act_block); // R4
  AST_SRE_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_SRE) |-> ($past(cmd_code) == CMD_REF)); // R5
  AST_CKE_FALL_ON_SRE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd_code == CMD_SRE)); // R5
  AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && (cmd_code != CMD_SRE)) |-> (cmd_code == CMD_NOP)); // R6
  AST_CKE_RISE_ON_SRX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd_code == CMD_SRX)); // R7
  AST_SRX_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_SRX) |=> ((cmd_code == CMD_NOP) && act_block)); // R7
  AST_SRE_NEEDS_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_SRE) |-> $past(!cfg_cke_cmd_mode)); // R9
  AST_SRX_FROM_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_SRX) |-> !$past(cke)); // R10
endmodule

bind sdr_rfsh_seq sdr_rfsh_seq_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cke_cmd_mode(cfg_cke_cmd_mode),
  .bus_gnt(bus_gnt), .bus_req(bus_req), .cmd_code(cmd_code),
  .cmd_bank_en(cmd_bank_en), .cke(cke), .act_block(act_block)
);

// File: tb/tb_sdr_rfsh_seq.sv
module tb_sdr_rfsh_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_NOP = 3'd0, C_PALL = 3'd1, C_REF = 3'd2,
                         C_SRE = 3'd3, C_SRX = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] cfg_interval;
  logic [1:0] cfg_recov;
  logic       cfg_sr_req, cfg_cke_cmd_mode;
  logic       gnt_auto, gnt_man;
  logic       bus_gnt, bus_req, cke, act_block;
  logic [2:0] cmd_code;
  logic [1:0] cmd_bank_en;
  int         cyc;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bus_gnt = gnt_auto ? bus_req : gnt_man;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  sdr_rfsh_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .cfg_recov(cfg_recov),
    .cfg_sr_req(cfg_sr_req), .cfg_cke_cmd_mode(cfg_cke_cmd_mode),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .cmd_code(cmd_code),
    .cmd_bank_en(cmd_bank_en), .cke(cke), .act_block(act_block)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cmd(input logic [2:0] c, output int at);
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (cmd_code == c) begin at = cyc; break; end
    end
  endtask

  task automatic wait_req_rise(output int at);
    at = -1;
    for (int i = 0; i < 2000 && bus_req; i++) @(negedge clk);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (bus_req) begin at = cyc; break; end
    end
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(cke && cmd_code == C_NOP && !bus_req && !act_block, "R1 in reset",
        {cke, cmd_code, bus_req, act_block}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cke && cmd_code == C_NOP && !bus_req && !act_block, "R1 after release",
        {cke, cmd_code, bus_req, act_block}, 6'b100000);
  endtask

  task automatic t_interval(input int rc);
    int a, b;
    cfg_interval = 9'(rc);
    gnt_auto = 1'b1;
    do_reset();
    wait_req_rise(a);
    chk(a == (rc + 1) * 16 + 2, "R2 first request", a, (rc + 1) * 16 + 2);
    wait_req_rise(b);
    chk(b - a == (rc + 1) * 16, "R2 spacing", b - a, (rc + 1) * 16);
  endtask

  task automatic t_grant();
    int a;
    bit quiet = 1'b1;
    cfg_interval = 9'd1;
    gnt_auto = 1'b0; gnt_man = 1'b0;
    do_reset();
    wait_req_rise(a);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (cmd_code != C_NOP || !bus_req) quiet = 1'b0;
    end
    chk(quiet, "R3 waits for grant", quiet, 1);
    gnt_man = 1'b1;
    @(negedge clk);
    chk(cmd_code == C_PALL && cmd_bank_en == 2'b11, "R3 precharge", {cmd_code, cmd_bank_en}, {C_PALL, 2'b11});
    @(negedge clk);
    chk(cmd_code == C_REF && cmd_bank_en == 2'b11, "R3 refresh", {cmd_code, cmd_bank_en}, {C_REF, 2'b11});
    @(negedge clk);
    chk(!bus_req && cmd_code == C_NOP, "R3 release", bus_req, 0);
    gnt_man = 1'b0;
    gnt_auto = 1'b1;
  endtask

  task automatic t_lockout(input logic [1:0] code, input int n);
    int t;
    bit held = 1'b1;
    cfg_recov = code;
    wait_cmd(C_REF, t);
    chk(t >= 0 && act_block, "R4 block at refresh", act_block, 1);
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      if (!act_block) held = 1'b0;
    end
    chk(held, "R4 block held", held, 1);
    @(negedge clk);
    chk(!act_block && cyc == t + n, "R4 block released", cyc - t, n);
  endtask

  task automatic t_sr_cycle();
    int t, s, r;
    bit quiet = 1'b1;
    logic [2:0] seq[3];
    int k = 0;
    cfg_sr_req = 1'b1;
    for (int i = 0; i < 50 && k < 3; i++) begin
      @(negedge clk);
      if (cmd_code != C_NOP) begin
        seq[k] = cmd_code;
        if (cmd_code != C_SRE && !cke) quiet = 1'b0;
        if (cmd_code == C_SRE) chk(!cke, "R5 cke low on entry", cke, 0);
        k++;
      end
    end
    chk(k == 3 && seq[0] == C_PALL && seq[1] == C_REF && seq[2] == C_SRE,
        "R5 entry order", {seq[0], seq[1], seq[2]}, {C_PALL, C_REF, C_SRE});
    chk(quiet, "R5 cke high before entry", quiet, 1);
    // R6: long stay, counter frozen, nothing issued
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (cke || cmd_code != C_NOP || !bus_req) quiet = 1'b0;
    end
    chk(quiet, "R6 quiet self-refresh", quiet, 1);
    cfg_sr_req = 1'b0;
    @(negedge clk);
    chk(cmd_code == C_SRX && cke, "R7 exit command", {cmd_code, cke}, {C_SRX, 1'b1});
    s = cyc;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (cmd_code != C_NOP || !act_block || !bus_req) quiet = 1'b0;
    end
    chk(quiet, "R7 recovery hold", quiet, 1);
    @(negedge clk);
    chk(!act_block && !bus_req && cyc == s + 9, "R7 recovery end", {act_block, bus_req}, 0);
    wait_req_rise(r);
    chk(r == s + 32 + 10, "R8 timer reload", r - s, 42);
  endtask

  task automatic t_cke_mode();
    int refs = 0;
    bit bad = 1'b0;
    cfg_cke_cmd_mode = 1'b1;
    cfg_sr_req = 1'b0;
    cfg_interval = 9'd1;
    do_reset();
    cfg_sr_req = 1'b1;
    for (int i = 0; i < 110; i++) begin
      @(negedge clk);
      if (cmd_code == C_REF) refs++;
      if (!cke || cmd_code == C_SRE || cmd_code == C_SRX) bad = 1'b1;
    end
    chk(!bad, "R9 request ignored", bad, 0);
    chk(refs == 3, "R9 refresh continues", refs, 3);
    cfg_sr_req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cmd_code == C_SRX) bad = 1'b1;
    end
    chk(!bad, "R10 no exit outside self-refresh", bad, 0);
    cfg_cke_cmd_mode = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_interval = 9'd1; cfg_recov = 2'b00;
    cfg_sr_req = 1'b0; cfg_cke_cmd_mode = 1'b0;
    gnt_auto = 1'b1; gnt_man = 1'b0;
    t_reset();
    t_interval(1);
    t_interval(0);
    t_interval(3);
    t_grant();
    cfg_interval = 9'd1;
    do_reset();
    t_lockout(2'b00, 3);
    t_lockout(2'b01, 6);
    t_lockout(2'b10, 9);
    t_lockout(2'b11, 9);
    t_sr_cycle();
    t_cke_mode();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule